// File: doc/BRIEF.md
# Two-Level Conflict Batch Queue

This block groups storage requests into batches whose members can run side by side. Every request brings a chip mask (bit i set means the request touches chip i) and a channel mask (bit i set means it touches channel i). The queue holds an ordered list of chip batches. Each chip batch holds an ordered list of channel batches. A chip batch records the union of the chip masks of its members. A channel batch records the union of the channel masks of its members.

A new request is placed first-fit at two levels. It goes into the oldest chip batch whose chip union it does not overlap. Within that batch, it goes into the oldest channel batch whose channel union it does not overlap. Each inspected batch costs one clock cycle. The block returns the placement of each request as a rank (0 = oldest live chip batch) and a channel-batch index. On request, the oldest chip batch is drained: every member comes out, channel batch by channel batch, and the batch is then freed.

The control is one state machine with five states. ST_IDLE waits for a request or a drain. ST_CHIP_SCAN inspects one chip batch per cycle. ST_CHAN_SCAN inspects one channel batch per cycle. ST_DONE presents the result for one cycle. ST_DRAIN emits one member per cycle. The transitions are:
- ST_IDLE goes to ST_DRAIN when `drain_req` is high and a batch exists. Otherwise it goes to ST_CHIP_SCAN when a request is accepted.
- ST_CHIP_SCAN goes to ST_DONE when it opens a new chip batch. It goes to ST_CHAN_SCAN when it finds a chip batch with no chip overlap.
- ST_CHAN_SCAN goes to ST_DONE on a join or a new channel batch. It returns to ST_CHIP_SCAN when the chip batch cannot take the request.
- ST_DONE returns to ST_IDLE.
- ST_DRAIN returns to ST_IDLE after the last member of the batch.

Top module: `conflict_batch_queue`

## Requirements
- R1: A chip conflict exists when a chip batch's chip union AND the request's chip mask is nonzero. The request joins the oldest chip batch without a chip conflict that can take it, and that batch's chip union becomes its OR with the request's chip mask.
- R2: When every live chip batch conflicts or cannot take the request, a new chip batch holding only this request is opened at rank equal to the number of live chip batches, with channel index 0.
- R3: Inside the chosen chip batch, the request joins the oldest channel batch whose channel union ANDed with the request's channel mask is zero, and that union is ORed with the request's channel mask. If all conflict, a new channel batch is opened at the next index.
- R4: A channel batch already holding NRQ requests is treated as conflicting.
- R5: A chip batch without a chip conflict, whose NHB channel batches all exist and all conflict or are full, is skipped, and the search continues at the next chip batch.
- R6: An all-zero chip mask or channel mask never conflicts.
- R7: The placement is reported by `res_valid` high for exactly one cycle, with `res_cb` as the rank (0 = oldest live chip batch), `res_hb` as the channel-batch index and `res_tag` as the request tag.
- R8: `in_ready` is low while a search is in progress, while `drain_req` is high, and while NCB chip batches are live. A request offered while `in_ready` is low is not taken and produces no result.
- R9: With `drain_req` high in ST_IDLE and at least one batch live, the oldest chip batch is emitted one member per cycle with `out_valid` high. Its channel batches are emitted in index order starting at 0, and the members of each come out in arrival order, with `out_hb` giving the channel batch. The batch is then freed and all ranks drop by one.
- R10: `drain_req` with no live batch produces no output.
- R11: After reset, `in_ready` is 1, and `res_valid` and `out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Request will be taken this cycle |
| in_chips | input | CHIP_W | Chip mask of the request |
| in_chans | input | CHAN_W | Channel mask of the request |
| in_tag | input | ID_W | Request tag |
| drain_req | input | 1 | Drain the oldest chip batch |
| res_valid | output | 1 | Placement result valid |
| res_cb | output | clog2(NCB) | Chip-batch rank of the placement |
| res_hb | output | clog2(NHB) | Channel-batch index of the placement |
| res_tag | output | ID_W | Tag of the placed request |
| out_valid | output | 1 | Drained member valid |
| out_tag | output | ID_W | Tag of the drained member |
| out_hb | output | clog2(NHB) | Channel batch of the drained member |

## Verification
The hardest situations to reach are the two skip paths. In the first, a chip batch is free of chip conflicts but its channel batch is full of requests (R4). In the second, all channel-batch slots of a chip batch are in use and conflict, so the search must fall through to the next chip batch (R5). The stimulus builds these cases on purpose. It fills one channel batch with four requests that have disjoint chips and disjoint channels. It then builds a chip batch with four channel batches that all use channel 0, using requests on separate chips. Draining between phases shows the rank shift through a later placement that lands at rank 0 of what used to be the second batch.

// File: rtl/cbq_pkg.sv
package cbq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHIP_SCAN,
        ST_CHAN_SCAN,
        ST_DONE,
        ST_DRAIN
    } cbq_state_e;

endpackage

// File: rtl/cbq_fit_check.sv
module cbq_fit_check #(
    parameter int W = 8
) (
    input  logic [W-1:0] set_mask,
    input  logic [W-1:0] req_mask,
    input  logic         full,
    output logic         fits
);

    // A candidate accepts the request when it has room and no shared bit.
    assign fits = !full && ((set_mask & req_mask) == '0);

endmodule

// File: rtl/cbq_ring_ptr.sv
module cbq_ring_ptr #(
    parameter int DEPTH = 4,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [PW-1:0] rank,
    output logic [PW-1:0] head,
    output logic [CW-1:0] count,
    output logic [PW-1:0] rank_slot
);

    localparam logic [PW:0] DEPTH_X = (PW + 1)'(DEPTH);

    logic [PW:0] sum;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head  <= '0;
            count <= '0;
        end else begin
            if (pop) begin
                head <= (head == PW'(DEPTH - 1)) ? '0 : head + 1'b1;
            end
            if (push && !pop) begin
                count <= count + 1'b1;
            end else if (pop && !push) begin
                count <= count - 1'b1;
            end
        end
    end

    // Age rank to physical slot, wrapping around the ring.
    always_comb begin
        sum = {1'b0, head} + {1'b0, rank};
        if (sum >= DEPTH_X) begin
            sum = sum - DEPTH_X;
        end
        rank_slot = sum[PW-1:0];
    end

endmodule

// File: rtl/conflict_batch_queue.sv
module conflict_batch_queue
    import cbq_pkg::*;
#(
    parameter int CHIP_W = 8,
    parameter int CHAN_W = 4,
    parameter int NCB    = 4,
    parameter int NHB    = 4,
    parameter int NRQ    = 4,
    parameter int ID_W   = 8,
    localparam int CBW   = $clog2(NCB),
    localparam int HBW   = $clog2(NHB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CHIP_W-1:0] in_chips,
    input  logic [CHAN_W-1:0] in_chans,
    input  logic [ID_W-1:0]   in_tag,
    input  logic              drain_req,
    output logic              res_valid,
    output logic [CBW-1:0]    res_cb,
    output logic [HBW-1:0]    res_hb,
    output logic [ID_W-1:0]   res_tag,
    output logic              out_valid,
    output logic [ID_W-1:0]   out_tag,
    output logic [HBW-1:0]    out_hb
);

    localparam int RQW  = $clog2(NRQ);
    localparam int CNTW = $clog2(NCB + 1);
    localparam int NHW  = $clog2(NHB + 1);
    localparam int RCW  = $clog2(NRQ + 1);

    cbq_state_e state, nxt;

    // Batch storage
    logic [CHIP_W-1:0] cb_chips [NCB];
    logic [NHW-1:0]    cb_nhb   [NCB];
    logic [CHAN_W-1:0] hb_chans [NCB][NHB];
    logic [RCW-1:0]    hb_cnt   [NCB][NHB];
    logic [ID_W-1:0]   tags     [NCB][NHB][NRQ];

    // Request under search and scan cursors
    logic [CHIP_W-1:0] req_chips;
    logic [CHAN_W-1:0] req_chans;
    logic [ID_W-1:0]   req_tag;
    logic [CBW-1:0]    pos;
    logic [NHW-1:0]    hb;
    logic [HBW-1:0]    hb_idx;
    logic [HBW-1:0]    dh;
    logic [RQW-1:0]    dr;
    logic [CBW-1:0]    res_cb_q;
    logic [HBW-1:0]    res_hb_q;

    logic [CBW-1:0]  head;
    logic [CNTW-1:0] count;
    logic [CBW-1:0]  slot;

    logic chip_ok, chan_ok, chan_full;
    logic at_end_chip, at_end_chan, can_new_hb;
    logic act_new_cb, act_enter_chan, act_skip_chip;
    logic act_new_hb, act_join, act_next_hb;
    logic last_in_hb, last_hb, act_free;
    logic accept, start_drain;

    assign hb_idx = hb[HBW-1:0];

    cbq_ring_ptr #(.DEPTH(NCB)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (act_new_cb),
        .pop       (act_free),
        .rank      (pos),
        .head      (head),
        .count     (count),
        .rank_slot (slot)
    );

    assign chan_full = (hb_cnt[slot][hb_idx] == RCW'(NRQ));

    cbq_fit_check #(.W(CHIP_W)) u_chip_fit (
        .set_mask (cb_chips[slot]),
        .req_mask (req_chips),
        .full     (1'b0),
        .fits     (chip_ok)
    );

    cbq_fit_check #(.W(CHAN_W)) u_chan_fit (
        .set_mask (hb_chans[slot][hb_idx]),
        .req_mask (req_chans),
        .full     (chan_full),
        .fits     (chan_ok)
    );

    // Decisions of the current cycle
    always_comb begin
        at_end_chip    = (CNTW'(pos) == count);
        at_end_chan    = (hb == cb_nhb[slot]);
        can_new_hb     = (cb_nhb[slot] < NHW'(NHB));
        act_new_cb     = (state == ST_CHIP_SCAN) && at_end_chip;
        act_enter_chan = (state == ST_CHIP_SCAN) && !at_end_chip && chip_ok;
        act_skip_chip  = ((state == ST_CHIP_SCAN) && !at_end_chip && !chip_ok) ||
                         ((state == ST_CHAN_SCAN) && at_end_chan && !can_new_hb);
        act_new_hb     = (state == ST_CHAN_SCAN) && at_end_chan && can_new_hb;
        act_join       = (state == ST_CHAN_SCAN) && !at_end_chan && chan_ok;
        act_next_hb    = (state == ST_CHAN_SCAN) && !at_end_chan && !chan_ok;
        last_in_hb     = ((RCW'(dr) + RCW'(1)) == hb_cnt[head][dh]);
        last_hb        = ((NHW'(dh) + NHW'(1)) == cb_nhb[head]);
        act_free       = (state == ST_DRAIN) && last_in_hb && last_hb;
        start_drain    = (state == ST_IDLE) && drain_req && (count != '0);
        accept         = in_valid && in_ready;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start_drain) begin
                    nxt = ST_DRAIN;
                end else if (accept) begin
                    nxt = ST_CHIP_SCAN;
                end
            end
            ST_CHIP_SCAN: begin
                if (act_new_cb) begin
                    nxt = ST_DONE;
                end else if (act_enter_chan) begin
                    nxt = ST_CHAN_SCAN;
                end
            end
            ST_CHAN_SCAN: begin
                if (act_new_hb || act_join) begin
                    nxt = ST_DONE;
                end else if (act_skip_chip) begin
                    nxt = ST_CHIP_SCAN;
                end
            end
            ST_DONE:  nxt = ST_IDLE;
            ST_DRAIN: begin
                if (act_free) begin
                    nxt = ST_IDLE;
                end
            end
            default:  nxt = ST_IDLE;
        endcase
    end

    // Cursors, captured request and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_chips <= '0;
            req_chans <= '0;
            req_tag   <= '0;
            pos       <= '0;
            hb        <= '0;
            dh        <= '0;
            dr        <= '0;
            res_cb_q  <= '0;
            res_hb_q  <= '0;
        end else begin
            if (accept) begin
                req_chips <= in_chips;
                req_chans <= in_chans;
                req_tag   <= in_tag;
                pos       <= '0;
            end
            if (act_enter_chan) begin
                hb <= '0;
            end
            if (act_next_hb) begin
                hb <= hb + 1'b1;
            end
            if (act_skip_chip) begin
                pos <= pos + 1'b1;
            end
            if (act_new_cb) begin
                res_cb_q <= pos;
                res_hb_q <= '0;
            end
            if (act_new_hb || act_join) begin
                res_cb_q <= pos;
                res_hb_q <= hb_idx;
            end
            if (start_drain) begin
                dh <= '0;
                dr <= '0;
            end else if (state == ST_DRAIN) begin
                if (!last_in_hb) begin
                    dr <= dr + 1'b1;
                end else if (!last_hb) begin
                    dh <= dh + 1'b1;
                    dr <= '0;
                end
            end
        end
    end

    // Masks and counts
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCB; c++) begin
                cb_chips[c] <= '0;
                cb_nhb[c]   <= '0;
                for (int h = 0; h < NHB; h++) begin
                    hb_chans[c][h] <= '0;
                    hb_cnt[c][h]   <= '0;
                end
            end
        end else begin
            if (act_new_cb) begin
                cb_chips[slot]    <= req_chips;
                cb_nhb[slot]      <= NHW'(1);
                hb_chans[slot][0] <= req_chans;
                hb_cnt[slot][0]   <= RCW'(1);
            end
            if (act_new_hb) begin
                cb_chips[slot]         <= cb_chips[slot] | req_chips;
                cb_nhb[slot]           <= cb_nhb[slot] + 1'b1;
                hb_chans[slot][hb_idx] <= req_chans;
                hb_cnt[slot][hb_idx]   <= RCW'(1);
            end
            if (act_join) begin
                cb_chips[slot]         <= cb_chips[slot] | req_chips;
                hb_chans[slot][hb_idx] <= hb_chans[slot][hb_idx] | req_chans;
                hb_cnt[slot][hb_idx]   <= hb_cnt[slot][hb_idx] + 1'b1;
            end
            if (act_free) begin
                cb_chips[head] <= '0;
                cb_nhb[head]   <= '0;
            end
        end
    end

    // Member tags
    always_ff @(posedge clk) begin
        if (act_new_cb) begin
            tags[slot][0][0] <= req_tag;
        end
        if (act_new_hb) begin
            tags[slot][hb_idx][0] <= req_tag;
        end
        if (act_join) begin
            tags[slot][hb_idx][hb_cnt[slot][hb_idx][RQW-1:0]] <= req_tag;
        end
    end

    // Outputs
    always_comb begin
        in_ready  = (state == ST_IDLE) && !drain_req && (count < CNTW'(NCB));
        res_valid = (state == ST_DONE);
        res_cb    = res_cb_q;
        res_hb    = res_hb_q;
        res_tag   = req_tag;
        out_valid = (state == ST_DRAIN);
        out_tag   = tags[head][dh][dr];
        out_hb    = dh;
    end

endmodule

// File: rtl/cbq_checker.sv
module cbq_checker #(
    parameter int HBW = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           in_ready,
    input logic           drain_req,
    input logic           res_valid,
    input logic           out_valid,
    input logic [HBW-1:0] out_hb
);

    // R8: a taken request blocks the next one while it is searched
    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R8: a pending drain blocks new requests
    assert_drain_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        drain_req |-> !in_ready);

    // R7: a result is shown for one cycle only
    assert_result_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R9: placement results and drained members never overlap
    assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && out_valid));

    // R9: a drain begins with channel batch 0
    assert_drain_starts_hb0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_hb == '0));

    // R9: channel batches leave in index order
    assert_hb_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> (out_hb >= $past(out_hb)));

endmodule

bind conflict_batch_queue cbq_checker #(.HBW(HBW)) u_cbq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .drain_req (drain_req),
    .res_valid (res_valid),
    .out_valid (out_valid),
    .out_hb    (out_hb)
);

// File: tb/test_conflict_batch_queue.sv
module test_conflict_batch_queue;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_chips = '0;
    logic [3:0] in_chans = '0;
    logic [7:0] in_tag = '0;
    logic       drain_req = 1'b0;
    logic       res_valid;
    logic [1:0] res_cb;
    logic [1:0] res_hb;
    logic [7:0] res_tag;
    logic       out_valid;
    logic [7:0] out_tag;
    logic [1:0] out_hb;

    int checks = 0;
    int errors = 0;
    int got_n;
    logic [7:0] got_tag [32];
    logic [1:0] got_hb  [32];

    always #(CLK_PERIOD / 2) clk = ~clk;

    conflict_batch_queue i_conflict_batch_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_chips  (in_chips),
        .in_chans  (in_chans),
        .in_tag    (in_tag),
        .drain_req (drain_req),
        .res_valid (res_valid),
        .res_cb    (res_cb),
        .res_hb    (res_hb),
        .res_tag   (res_tag),
        .out_valid (out_valid),
        .out_tag   (out_tag),
        .out_hb    (out_hb)
    );

    // Entry: chips[23:16] chans[15:12] tag[11:4] rank[3:2] channel-batch[1:0]
    localparam logic [23:0] VEC [12] = '{
        24'h036110,  // R2 first batch
        24'h343121,  // R3 channel conflict opens channel batch 1
        24'hC0C131,  // R1 R3 joins chip batch 0, channel batch 1
        24'h401144,  // R1 R2 chip 6 now taken, new chip batch
        24'h081150,  // R1 R3 chip 3 still free in batch 0
        24'h082164,  // R1 skips conflicting batch 0
        24'h018174,
        24'h024184,  // channel batch reaches four requests
        24'h100195,  // R4 full channel batch skipped
        24'h0001A0,  // R6 empty masks
        24'hFFF1B8,  // R2
        24'h0111CC   // R2 last free chip batch
    };

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic send(input string rq, input logic [7:0] chips, input logic [3:0] chans,
                        input logic [7:0] tag, input logic [1:0] ecb, input logic [1:0] ehb);
        int n;
        @(negedge clk);
        in_chips = chips;
        in_chans = chans;
        in_tag   = tag;
        in_valid = 1'b1;
        chk("R8", "ready before request", 32'(in_ready), 32'd1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        n = 0;
        while (!res_valid && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk("R7", "res_valid", 32'(res_valid), 32'd1);
        chk(rq, "rank", 32'(res_cb), 32'(ecb));
        chk(rq, "channel batch", 32'(res_hb), 32'(ehb));
        chk("R7", "tag", 32'(res_tag), 32'(tag));
    endtask

    task automatic run_drain();
        @(negedge clk);
        drain_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        drain_req = 1'b0;
        got_n = 0;
        while (out_valid && got_n < 32) begin
            got_tag[got_n] = out_tag;
            got_hb[got_n]  = out_hb;
            got_n++;
            @(negedge clk);
        end
    endtask

    task automatic expect_out(input int idx, input logic [7:0] tag, input logic [1:0] hb);
        chk("R9", "drain tag", 32'(got_tag[idx]), 32'(tag));
        chk("R9", "drain channel batch", 32'(got_hb[idx]), 32'(hb));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11", "in_ready", 32'(in_ready), 32'd1);
        chk("R11", "res_valid", 32'(res_valid), 32'd0);
        chk("R11", "out_valid", 32'(out_valid), 32'd0);

        for (int i = 0; i < 12; i++) begin
            send("R1", VEC[i][23:16], VEC[i][15:12], VEC[i][11:4], VEC[i][3:2], VEC[i][1:0]);
        end

        // R8: four chip batches live, offers are refused
        @(negedge clk);
        chk("R8", "ready when full", 32'(in_ready), 32'd0);
        in_chips = 8'h00;
        in_chans = 4'h0;
        in_tag   = 8'hEE;
        in_valid = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R8", "no result while full", 32'(res_valid), 32'd0);
        end
        in_valid = 1'b0;

        // R9: oldest batch leaves, channel batch 0 first, arrival order
        run_drain();
        chk("R9", "count drained", 32'(got_n), 32'd5);
        expect_out(0, 8'h11, 2'd0);
        expect_out(1, 8'h15, 2'd0);
        expect_out(2, 8'h1A, 2'd0);
        expect_out(3, 8'h12, 2'd1);
        expect_out(4, 8'h13, 2'd1);

        // R9: ranks dropped by one, former batch 1 is now rank 0
        send("R9", 8'h20, 4'h0, 8'h1D, 2'd0, 2'd1);
        run_drain();
        chk("R9", "count drained", 32'(got_n), 32'd6);
        expect_out(0, 8'h14, 2'd0);
        expect_out(1, 8'h16, 2'd0);
        expect_out(2, 8'h17, 2'd0);
        expect_out(3, 8'h18, 2'd0);
        expect_out(4, 8'h19, 2'd1);
        expect_out(5, 8'h1D, 2'd1);
        run_drain();
        chk("R9", "count drained", 32'(got_n), 32'd1);
        expect_out(0, 8'h1B, 2'd0);
        run_drain();
        chk("R9", "count drained", 32'(got_n), 32'd1);
        expect_out(0, 8'h1C, 2'd0);

        // R10: drain of an empty queue gives nothing
        @(negedge clk);
        drain_req = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R10", "out_valid on empty", 32'(out_valid), 32'd0);
            chk("R8", "ready during drain_req", 32'(in_ready), 32'd0);
        end
        drain_req = 1'b0;

        // R5: chip batch with four conflicting channel batches is passed over
        send("R3", 8'h01, 4'h1, 8'h21, 2'd0, 2'd0);
        send("R3", 8'h02, 4'h1, 8'h22, 2'd0, 2'd1);
        send("R3", 8'h04, 4'h1, 8'h23, 2'd0, 2'd2);
        send("R3", 8'h08, 4'h1, 8'h24, 2'd0, 2'd3);
        send("R5", 8'h10, 4'h1, 8'h25, 2'd1, 2'd0);
        send("R3", 8'h20, 4'h2, 8'h26, 2'd0, 2'd0);
        run_drain();
        chk("R9", "count drained", 32'(got_n), 32'd5);
        expect_out(0, 8'h21, 2'd0);
        expect_out(1, 8'h26, 2'd0);
        expect_out(2, 8'h22, 2'd1);
        expect_out(3, 8'h23, 2'd2);
        expect_out(4, 8'h24, 2'd3);
        run_drain();
        chk("R9", "count drained", 32'(got_n), 32'd1);
        expect_out(0, 8'h25, 2'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule